// File: doc/BRIEF.md
# Handshaked Serial Link Transmitter

This block drives one serial output wire that carries two kinds of traffic: data bytes written by a host, and short acknowledge tokens requested by a companion receiver. A data byte is framed as an 11-bit packet. An acknowledge is a 2-bit packet. The bit period comes from a divider on the system clock, and a speed-select input chooses between the two link rates.

A data byte is not released when its last bit leaves the wire. The block holds the byte slot busy until the far end returns an acknowledge, which the receiver reports through a one-cycle pulse. Only then is the host allowed to write the next byte.

Both producers use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. When ready is low, the producer must hold its request, and a valid asserted while ready is low is not taken. Each handshake has one slot:

- The data slot frees only after the far end acknowledges the byte.
- The acknowledge slot frees as soon as its packet begins serialising.

Top module: `lnk_tx`

## Requirements
- R1: `link_out` is low while `rst_n` is low and whenever no packet is being serialised.
- R2: A data packet is 11 bits, sent in this order: a 1, a 1, the eight data bits with bit 0 first, then a 0.
- R3: An acknowledge packet is 2 bits, sent in this order: a 1, then a 0.
- R4: One bit lasts CLK_HZ/RATE_LO cycles when `speed_hi` is 0, and CLK_HZ/(2·RATE_LO) cycles when `speed_hi` is 1. With the default parameters this is 12 cycles and 6 cycles.
- R5: `speed_hi` is sampled only when a packet is loaded. A change of `speed_hi` during a packet does not alter that packet's bit period.
- R6: `tx_ready` is high after reset. A byte is accepted on an edge where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low from the next cycle on. If the wire is idle, the start bit appears P+1 cycles after the accepting edge, where P is the bit period.
- R7: `tx_ready` stays low after the data packet ends, and rises in the cycle after the first `rx_ack` pulse that arrives once the packet has finished. An `rx_ack` pulse that arrives while the packet is still queued or being sent is ignored.
- R8: An acknowledge request is accepted when `ack_valid` and `ack_ready` are both high. `ack_ready` is then low until the acknowledge packet is loaded. If the wire is idle, the acknowledge starts P+1 cycles after the accepting edge.
- R9: A packet in progress is never interrupted. When a packet ends, the next one starts P+1 cycles after the last bit period ends. If an acknowledge and a data byte are both waiting when a packet is chosen, the acknowledge goes first.
- R10: `tx_valid` is ignored while `tx_ready` is low. The held byte is not replaced, and no extra packet is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| speed_hi | input | 1 | 0 selects the low rate, 1 selects double rate |
| tx_valid | input | 1 | Host offers a data byte |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Data slot is free: the previous byte has been delivered and acknowledged |
| ack_valid | input | 1 | Receiver asks for an acknowledge packet |
| ack_ready | output | 1 | Acknowledge slot is free |
| rx_ack | input | 1 | One-cycle pulse: an acknowledge has arrived from the far end |
| link_out | output | 1 | Serial line |

## Verification
All results have fixed delays, so the bench can predict the exact cycle for each one:

- `tx_ready` and `ack_ready` change in the cycle after the handshake edge.
- `tx_ready` rises in the cycle after the `rx_ack` edge.
- On an idle wire, a start bit is first seen P+1 cycles after the accepting edge.
- A queued packet starts P+1 cycles after the previous packet's last bit period ends.

The bench drives inputs and samples outputs on falling edges. It counts cycles from the accepting edge, or from the first idle cycle, up to the start bit. It then compares the line in every cycle of the packet against the bit that the expected frame and period give for that cycle. As a result, any error in period, ordering or latency shows up as a mismatch at a known cycle.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = DATA_BITS + 3;
  localparam int ACK_BITS   = 2;

  typedef enum logic [1:0] {SH_IDLE, SH_LEAD, SH_SEND} sh_state_t;
  typedef enum logic [1:0] {DQ_EMPTY, DQ_QUEUED, DQ_SENDING, DQ_WAITACK} dq_state_t;
  typedef enum logic {PK_ACK, PK_DATA} pk_kind_t;
endpackage

// File: rtl/lnk_bit_timer.sv
module lnk_bit_timer #(
  parameter int P_LO = 12,
  parameter int P_HI = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  input  logic speed_hi,
  output logic tick
);
  localparam int CW = $clog2(P_LO + 1);
  localparam logic [CW-1:0] LIM_LO = CW'(P_LO - 1);
  localparam logic [CW-1:0] LIM_HI = CW'(P_HI - 1);

  logic [CW-1:0] cnt;
  logic          hi_q;
  logic [CW-1:0] lim;

  assign lim  = hi_q ? LIM_HI : LIM_LO;
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hi_q <= 1'b0;
    end else if (load) begin
      cnt  <= '0;
      hi_q <= speed_hi;
    end else if (run) begin
      cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lnk_tx_arb.sv
module lnk_tx_arb
  import lnk_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_valid,
  input  logic [DATA_BITS-1:0] tx_data,
  output logic                 tx_ready,
  input  logic                 ack_valid,
  output logic                 ack_ready,
  input  logic                 rx_ack,
  input  logic                 take,
  input  logic                 done,
  output logic                 req_valid,
  output pk_kind_t             req_kind,
  output logic [DATA_BITS-1:0] req_data
);
  dq_state_t dq;
  logic      ack_pend;

  assign tx_ready  = (dq == DQ_EMPTY);
  assign ack_ready = !ack_pend;
  assign req_valid = ack_pend || (dq == DQ_QUEUED);
  assign req_kind  = ack_pend ? PK_ACK : PK_DATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_pend <= 1'b0;
    end else if (ack_valid && !ack_pend) begin
      ack_pend <= 1'b1;
    end else if (take && req_kind == PK_ACK) begin
      ack_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq       <= DQ_EMPTY;
      req_data <= '0;
    end else begin
      case (dq)
        DQ_EMPTY: if (tx_valid) begin
          dq       <= DQ_QUEUED;
          req_data <= tx_data;
        end
        DQ_QUEUED:  if (take && req_kind == PK_DATA) dq <= DQ_SENDING;
        DQ_SENDING: if (done) dq <= DQ_WAITACK;
        DQ_WAITACK: if (rx_ack) dq <= DQ_EMPTY;
        default:    dq <= DQ_EMPTY;
      endcase
    end
  end
endmodule

// File: rtl/lnk_tx_shift.sv
module lnk_tx_shift
  import lnk_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  pk_kind_t             req_kind,
  input  logic [DATA_BITS-1:0] req_data,
  input  logic                 tick,
  output logic                 take,
  output logic                 done,
  output logic                 busy,
  output logic                 link_out
);
  localparam int LW = $clog2(FRAME_BITS + 1);

  sh_state_t             st;
  logic [FRAME_BITS-1:0] sr;
  logic [LW-1:0]         left;

  assign take     = (st == SH_IDLE) && req_valid;
  assign busy     = (st != SH_IDLE);
  assign done     = (st == SH_SEND) && tick && (left == LW'(1));
  assign link_out = (st == SH_SEND) && sr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SH_IDLE;
      sr   <= '0;
      left <= '0;
    end else begin
      case (st)
        SH_IDLE: if (take) begin
          st <= SH_LEAD;
          if (req_kind == PK_DATA) begin
            sr   <= {1'b0, req_data, 2'b11};
            left <= LW'(FRAME_BITS);
          end else begin
            sr   <= FRAME_BITS'(2'b01);
            left <= LW'(ACK_BITS);
          end
        end
        SH_LEAD: if (tick) st <= SH_SEND;
        SH_SEND: if (tick) begin
          sr   <= sr >> 1;
          left <= left - 1'b1;
          if (left == LW'(1)) st <= SH_IDLE;
        end
        default: st <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lnk_tx.sv
module lnk_tx
  import lnk_tx_pkg::*;
#(
  parameter int CLK_HZ  = 120_000_000,
  parameter int RATE_LO = 10_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_hi,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  input  logic       ack_valid,
  output logic       ack_ready,
  input  logic       rx_ack,
  output logic       link_out
);
  localparam int P_LO = CLK_HZ / RATE_LO;
  localparam int P_HI = CLK_HZ / (2 * RATE_LO);

  logic                 sh_take, sh_done, sh_busy, tick;
  logic                 req_valid;
  pk_kind_t             req_kind;
  logic [DATA_BITS-1:0] req_data;

  lnk_tx_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .ack_valid(ack_valid), .ack_ready(ack_ready), .rx_ack(rx_ack),
    .take(sh_take), .done(sh_done),
    .req_valid(req_valid), .req_kind(req_kind), .req_data(req_data)
  );

  lnk_tx_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_data(req_data),
    .tick(tick), .take(sh_take), .done(sh_done), .busy(sh_busy),
    .link_out(link_out)
  );

  lnk_bit_timer #(.P_LO(P_LO), .P_HI(P_HI)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(sh_take), .run(sh_busy),
    .speed_hi(speed_hi), .tick(tick)
  );
endmodule

// File: rtl/lnk_tx_checks.sv
module lnk_tx_checks (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic ack_valid,
  input logic ack_ready,
  input logic rx_ack,
  input logic link_out,
  input logic busy,
  input logic rate_hi
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_low: assert (!link_out);
    end
  end

  a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);

  a_r7_ready_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready && !rx_ack |=> !tx_ready);

  a_r8_ack_slot: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && ack_ready |=> !ack_ready);

  a_r5_rate_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(rate_hi));
endmodule

bind lnk_tx lnk_tx_checks u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .ack_valid(ack_valid), .ack_ready(ack_ready), .rx_ack(rx_ack),
  .link_out(link_out), .busy(sh_busy), .rate_hi(u_tmr.hi_q)
);

// File: tb/lnk_tx_test.sv
module lnk_tx_test;
  localparam int CLK_HZ = 120_000_000;
  localparam int RATE   = 10_000_000;
  localparam int PLO    = CLK_HZ / RATE;
  localparam int PHI    = CLK_HZ / (2 * RATE);

  logic clk = 0, rst_n = 0, speed_hi = 0;
  logic tx_valid = 0, ack_valid = 0, rx_ack = 0;
  logic [7:0] tx_data = 0;
  logic tx_ready, ack_ready, link_out;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  lnk_tx #(.CLK_HZ(CLK_HZ), .RATE_LO(RATE)) uut (
    .clk(clk), .rst_n(rst_n), .speed_hi(speed_hi), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .ack_valid(ack_valid),
    .ack_ready(ack_ready), .rx_ack(rx_ack), .link_out(link_out)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit frame_bit(bit is_data, logic [7:0] d, int idx);
    if (!is_data) return (idx == 0);
    if (idx < 2) return 1'b1;
    if (idx < 10) return d[idx-2];
    return 1'b0;
  endfunction

  task automatic wait_start(int exp_n, string req);
    int n = 0;
    while (!link_out && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n == exp_n, req, n, exp_n);
  endtask

  task automatic expect_frame(bit is_data, logic [7:0] d, int p, string req,
                              bit flip, bit spur);
    int nb  = is_data ? 11 : 2;
    int bad = 0;
    for (int i = 0; i < nb * p; i++) begin
      if (link_out !== frame_bit(is_data, d, i / p)) bad++;
      if (flip && i == p) speed_hi = ~speed_hi;
      rx_ack = spur && (i == 2 * p);
      @(negedge clk);
    end
    rx_ack = 0;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic send_byte(logic [7:0] d, int p, bit flip, bit spur);
    chk(tx_ready == 1, "R6 ready before write", tx_ready, 1);
    tx_valid = 1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 0;
    chk(tx_ready == 0, "R6 ready drops", tx_ready, 0);
    wait_start(p + 1, "R6 start latency");
    expect_frame(1, d, p, "R2 data frame", flip, spur);
    chk(tx_ready == 0, "R7 ready low after frame", tx_ready, 0);
  endtask

  task automatic finish_ack(int dly);
    for (int i = 0; i < dly; i++) begin
      chk(link_out == 0, "R1 idle low", link_out, 0);
      @(negedge clk);
    end
    chk(tx_ready == 0, "R7 waiting for ack", tx_ready, 0);
    rx_ack = 1;
    @(negedge clk);
    rx_ack = 0;
    chk(tx_ready == 1, "R7 ready after ack", tx_ready, 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    chk(link_out == 0, "R1 reset low", link_out, 0);
    chk(tx_ready == 1, "R6 reset ready", tx_ready, 1);
    chk(ack_ready == 1, "R8 reset ack ready", ack_ready, 1);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R4 low rate, then high rate
    send_byte(8'hA5, PLO, 0, 0);
    finish_ack(5);
    speed_hi = 1;
    send_byte(8'h3C, PHI, 0, 0);
    finish_ack(2);

    // R5 rate change mid-packet has no effect
    speed_hi = 0;
    send_byte(8'h81, PLO, 1, 0);
    finish_ack(1);
    send_byte(8'h7E, PHI, 0, 0);
    finish_ack(1);
    speed_hi = 0;

    // R8 acknowledge request alone, R3 frame
    chk(ack_ready == 1, "R8 ack slot free", ack_ready, 1);
    ack_valid = 1;
    @(negedge clk);
    ack_valid = 0;
    chk(ack_ready == 0, "R8 ack slot taken", ack_ready, 0);
    wait_start(PLO + 1, "R8 ack latency");
    expect_frame(0, 8'h00, PLO, "R3 ack frame", 0, 0);
    chk(ack_ready == 1, "R8 ack slot freed", ack_ready, 1);

    // R9 both waiting: acknowledge first
    tx_valid = 1; tx_data = 8'h5A; ack_valid = 1;
    @(negedge clk);
    tx_valid = 0; ack_valid = 0;
    wait_start(PLO + 1, "R9 ack first latency");
    expect_frame(0, 8'h00, PLO, "R9 ack goes first", 0, 0);
    wait_start(PLO + 1, "R9 deferred data latency");
    expect_frame(1, 8'h5A, PLO, "R9 data after ack", 0, 0);
    finish_ack(3);

    // R9 no preemption: ack requested after data is loaded
    tx_valid = 1; tx_data = 8'hC3;
    @(negedge clk);
    tx_valid = 0; ack_valid = 1;
    @(negedge clk);
    ack_valid = 0;
    wait_start(PLO, "R9 data kept order");
    expect_frame(1, 8'hC3, PLO, "R9 data not interrupted", 0, 0);
    wait_start(PLO + 1, "R9 ack after data");
    expect_frame(0, 8'h00, PLO, "R9 ack after data frame", 0, 0);
    finish_ack(2);

    // R10 writes while not ready are ignored
    send_byte(8'h96, PLO, 0, 0);
    tx_valid = 1; tx_data = 8'h00;
    repeat (10) @(negedge clk);
    tx_valid = 0;
    finish_ack(1);
    begin
      int hi = 0;
      for (int i = 0; i < 3 * PLO; i++) begin
        if (link_out) hi++;
        @(negedge clk);
      end
      chk(hi == 0, "R10 no extra packet", hi, 0);
      chk(tx_ready == 1, "R10 slot still free", tx_ready, 1);
    end

    // R7 random traffic with ignored early acknowledges
    for (int k = 0; k < 16; k++) begin
      logic [7:0] d = 8'($urandom);
      bit sp = 1'($urandom);
      speed_hi = sp;
      send_byte(d, sp ? PHI : PLO, 0, 1);
      finish_ack(int'($urandom % 5));
    end

    summary();
    $finish;
  end
endmodule